// File: doc/BRIEF.md
# I2C Byte Master Engine

This block is the bit-level core of an I2C bus master. A host hands it one command at a time. Each command holds an 8-bit byte and three flags. The flags say whether the engine drives the byte, whether it puts a START condition first, and whether it puts a STOP condition after the acknowledge slot. The engine then runs the whole byte transfer on its own. It reports that it is busy, the acknowledge result and the byte it saw on the data line.

SCL is made inside the host clock domain. A clock-enable fires every `DIV` system clocks and moves a two-bit phase counter, so one SCL period holds four phases. Phases 0 and 1 hold SCL low and phases 2 and 3 release it. The engine changes SDA on entry to phase 1 and samples it on entry to phase 3. Both lines are open drain: the block only outputs pull-low enables, and the bench or pads resolve the wired level.

A master sequence is built from a chain of commands. For example, a write with START carries the address, further writes or reads move the data, and the last command has STOP set. Between commands without STOP, the engine keeps SCL pulled low so the bus stays owned.

Top module: `i2c_byte_master`

## Requirements
- R1: After a command is accepted, `busy` goes high on the next cycle. It stays high for exactly 4*DIV*(9 + start + stop) cycles, because each START, data, acknowledge and STOP slot lasts four phases of DIV cycles each.
- R2: A START condition (SDA falling while SCL is high) occurs once in a command whose start flag is set, and never in a command whose start flag is clear.
- R3: A STOP condition (SDA rising while SCL is high) occurs once in a command whose stop flag is set, and never otherwise. After such a command, both SCL and SDA are released.
- R4: Apart from START and STOP, SDA never changes while SCL is high.
- R5: Data goes out most significant bit first on eight SCL pulses. With write-enable set, the line carries the command byte. With it clear, the engine releases SDA so the slave's bits appear on the line.
- R6: At the end of each command, `rx_byte` holds the eight SDA levels sampled at the data bits, first-sampled bit as bit 7. This also holds when the engine drove the byte itself.
- R7: In a write, the engine releases SDA during the ninth (acknowledge) SCL pulse. `ack` becomes 1 if SDA was sampled low there and 0 if it was high.
- R8: In a read, the engine pulls SDA low in the acknowledge slot when the stop flag is clear, and releases it when the stop flag is set. `ack` then reports the sampled level the same way: 1 for low, 0 for high.
- R9: A command finishing without STOP leaves SCL pulled low while the engine is idle.
- R10: A `cmd_valid` pulse that arrives while `busy` is high is ignored. The running transfer keeps its timing and data, and no second transfer follows.
- R11: After reset, `busy`, `ack` and `rx_byte` are 0 and neither line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_we | input | 1 | 1: drive the byte; 0: release SDA for the data bits |
| cmd_start | input | 1 | Put a START condition before the byte |
| cmd_stop | input | 1 | Put a STOP condition after the acknowledge slot |
| cmd_byte | input | 8 | Byte to send, MSB first |
| busy | output | 1 | Command in progress |
| ack | output | 1 | 1 if SDA was low in the last acknowledge slot |
| rx_byte | output | 8 | Byte sampled from SDA in the last command |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The hardest situation to reach is a repeated START that follows a read without STOP. Here the engine has parked SCL low while still pulling SDA for its own acknowledge, and it must free SDA before letting SCL rise, or the bus would see a false STOP. The stimulus builds that chain on purpose: a read without STOP is followed at once by a command with START. Random chains of commands with random flags then revisit it, and along the way they place stray command strobes at random cycles inside busy transfers. A bench slave model drives data bits and acknowledges from the slot schedule. A line monitor counts every SDA edge that occurs while SCL is high.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        SL_START = 2'd0,
        SL_BIT   = 2'd1,
        SL_ACK   = 2'd2,
        SL_STOP  = 2'd3
    } slot_e;

    typedef struct packed {
        logic we;
        logic start;
        logic stop;
    } cmd_flags_t;

    // phases 0 and 1 are the low half of an SCL period
    function automatic logic low_half(input logic [1:0] ph);
        return ~ph[1];
    endfunction

endpackage

// File: rtl/i2c_bm_quarter_timer.sv
module i2c_bm_quarter_timer #(
    parameter int unsigned DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic       tick,
    output logic [1:0] phase
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic [1:0]       phase_q;

    assign tick  = run && (div_q == DIV_W'(DIV - 1));
    assign phase = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q   <= '0;
            phase_q <= 2'd0;
        end else if (tick) begin
            div_q   <= '0;
            phase_q <= phase_q + 2'd1;
        end else begin
            div_q   <= div_q + DIV_W'(1);
        end
    end

    // R1: the phase only moves on a quarter tick
    p_phase_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase_q));

endmodule

// File: rtl/i2c_bm_shifter.sv
module i2c_bm_shifter
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tx_step,
    input  logic              rx_step,
    input  logic              ack_step,
    input  logic              sda_in,
    output logic              tx_msb,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack
);
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] rx_q;
    logic              ack_q;

    assign tx_msb  = tx_sr[BYTE_W-1];
    assign rx_byte = rx_q;
    assign ack     = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
            rx_q  <= '0;
            ack_q <= 1'b0;
        end else begin
            if (load)
                tx_sr <= load_byte;
            else if (tx_step)
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            if (rx_step)
                rx_sr <= {rx_sr[BYTE_W-2:0], sda_in};
            if (ack_step) begin
                rx_q  <= rx_sr;
                ack_q <= ~sda_in;
            end
        end
    end

    // R6: the reported byte changes only when the acknowledge slot samples
    p_rx_only_at_ack_r6: assert property (@(posedge clk) disable iff (rst)
        !ack_step |=> $stable(rx_q));

endmodule

// File: rtl/i2c_bm_sequencer.sv
module i2c_bm_sequencer
    import i2c_bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  cmd_flags_t cmd_in,
    input  logic       tick,
    input  logic [1:0] phase,
    input  logic       tx_msb,
    output logic       busy,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       load,
    output logic       tx_step,
    output logic       rx_step,
    output logic       ack_step
);
    logic             busy_q;
    logic             parked_q;
    logic             sda_q;
    slot_e            slot_q;
    logic [IDX_W-1:0] idx_q;
    cmd_flags_t       cmd_q;
    logic             step;

    assign load     = cmd_valid && !busy_q;
    assign step     = busy_q && tick;
    assign tx_step  = step && (phase == 2'd0) && (slot_q == SL_BIT);
    assign rx_step  = step && (phase == 2'd2) && (slot_q == SL_BIT);
    assign ack_step = step && (phase == 2'd2) && (slot_q == SL_ACK);
    assign busy     = busy_q;
    assign sda_pull = sda_q;

    always_comb begin
        if (!busy_q)
            scl_pull = parked_q;
        else if (slot_q == SL_START)
            scl_pull = parked_q && (phase == 2'd0);
        else
            scl_pull = low_half(phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            parked_q <= 1'b0;
            sda_q    <= 1'b0;
            slot_q   <= SL_BIT;
            idx_q    <= '0;
            cmd_q    <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            cmd_q  <= cmd_in;
            idx_q  <= '0;
            slot_q <= cmd_in.start ? SL_START : SL_BIT;
            if (cmd_in.start)
                sda_q <= 1'b0;
        end else if (step) begin
            unique case (phase)
                2'd0: begin
                    unique case (slot_q)
                        SL_BIT:  sda_q <= cmd_q.we && !tx_msb;
                        SL_ACK:  sda_q <= !cmd_q.we && !cmd_q.stop;
                        SL_STOP: sda_q <= 1'b1;
                        default: ;
                    endcase
                end
                2'd2: begin
                    if (slot_q == SL_START)
                        sda_q <= 1'b1;
                    else if (slot_q == SL_STOP)
                        sda_q <= 1'b0;
                end
                2'd3: begin
                    unique case (slot_q)
                        SL_START: slot_q <= SL_BIT;
                        SL_BIT: begin
                            if (idx_q == IDX_W'(BYTE_W - 1))
                                slot_q <= SL_ACK;
                            idx_q <= idx_q + IDX_W'(1);
                        end
                        SL_ACK: begin
                            if (cmd_q.stop) begin
                                slot_q <= SL_STOP;
                            end else begin
                                busy_q   <= 1'b0;
                                parked_q <= 1'b1;
                            end
                        end
                        SL_STOP: begin
                            busy_q   <= 1'b0;
                            parked_q <= 1'b0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R4: data and acknowledge slots keep SDA still while SCL is high
    p_sda_still_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (slot_q == SL_BIT || slot_q == SL_ACK) && !scl_pull && $past(!scl_pull))
        |-> $stable(sda_q));

    // R1: a transfer only ends on the last phase of a slot
    p_end_on_slot_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(tick) && $past(phase) == 2'd3));

    // R3: an idle bus that is not parked has both lines released
    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !parked_q) |-> (!scl_pull && !sda_q));

    // R10: a strobe during a transfer leaves the latched flags alone
    p_ignore_busy_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_valid) |=> $stable(cmd_q));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              busy,
    output logic              ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              sda_in
);
    logic       tick;
    logic [1:0] phase;
    logic       tx_msb;
    logic       load;
    logic       tx_step;
    logic       rx_step;
    logic       ack_step;
    cmd_flags_t flags;

    assign flags = '{we: cmd_we, start: cmd_start, stop: cmd_stop};

    i2c_bm_quarter_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .tick  (tick),
        .phase (phase)
    );

    i2c_bm_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (flags),
        .tick      (tick),
        .phase     (phase),
        .tx_msb    (tx_msb),
        .busy      (busy),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .load      (load),
        .tx_step   (tx_step),
        .rx_step   (rx_step),
        .ack_step  (ack_step)
    );

    i2c_bm_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (cmd_byte),
        .tx_step   (tx_step),
        .rx_step   (rx_step),
        .ack_step  (ack_step),
        .sda_in    (sda_in),
        .tx_msb    (tx_msb),
        .rx_byte   (rx_byte),
        .ack       (ack)
    );

endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;

    localparam int unsigned DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_we = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       busy;
    logic       ack;
    logic [7:0] rx_byte;
    logic       scl_pull;
    logic       sda_pull;
    logic       slave_pull = 1'b0;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    assign sda_line = !(sda_pull || slave_pull);

    always #5 clk = ~clk;

    i2c_byte_master #(.DIV(DIV)) uut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_we    (cmd_we),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_byte  (cmd_byte),
        .busy      (busy),
        .ack       (ack),
        .rx_byte   (rx_byte),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .sda_in    (sda_line)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected byte seen on the wire and in rx_byte
    function automatic logic [7:0] exp_wire(input logic we, input logic [7:0] b,
                                            input logic [7:0] sb);
        return we ? b : sb;
    endfunction

    // expected ack status: write takes the slave's answer, read reflects own drive
    function automatic logic exp_ack(input logic we, input logic sp, input logic sack);
        return we ? sack : !sp;
    endfunction

    task automatic run_cmd(input logic we, input logic st, input logic sp,
                           input logic [7:0] b, input logic [7:0] sb,
                           input logic sack, input logic inj);
        int n;
        int total;
        int inj_c;
        int t;
        int idx;
        int starts;
        int stops;
        int busy_bad;
        logic [7:0] wire_bits;
        logic wire_ack;
        logic pscl;
        logic psda;
        logic scl_now;
        logic sda_now;
        n = 9 + int'(st) + int'(sp);
        total = 4 * DIV * n;
        inj_c = 1 + int'($urandom % 32'(total - 3));
        starts = 0;
        stops = 0;
        busy_bad = 0;
        wire_bits = 8'h00;
        wire_ack = 1'b1;
        cmd_we = we;
        cmd_start = st;
        cmd_stop = sp;
        cmd_byte = b;
        cmd_valid = 1'b1;
        pscl = !scl_pull;
        psda = sda_line;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c <= total; c++) begin
            if (c > 0) @(negedge clk);
            scl_now = !scl_pull;
            sda_now = sda_line;
            t = c / DIV;
            idx = t / 4 - int'(st);
            if (busy !== (c < total)) busy_bad++;
            if (pscl && scl_now && psda && !sda_now) starts++;
            if (pscl && scl_now && !psda && sda_now) stops++;
            if (!pscl && scl_now && c < total) begin
                if (idx >= 0 && idx < 8) wire_bits = {wire_bits[6:0], sda_now};
                else if (idx == 8) wire_ack = sda_now;
            end
            slave_pull = 1'b0;
            if (c < total) begin
                if (idx >= 0 && idx < 8 && !we) slave_pull = !sb[7 - idx];
                else if (idx == 8 && we) slave_pull = sack;
            end
            if (inj && c == inj_c) begin
                cmd_valid = 1'b1;
                cmd_we = ~we;
                cmd_start = ~st;
                cmd_stop = ~sp;
                cmd_byte = ~b;
            end else begin
                cmd_valid = 1'b0;
            end
            pscl = scl_now;
            psda = sda_now;
        end
        check(busy_bad == 0, "R1", "busy window mismatches", busy_bad, 0);
        check(starts == int'(st), "R2", "START count", starts, int'(st));
        check(stops == int'(sp), "R3", "STOP count", stops, int'(sp));
        check(wire_bits == exp_wire(we, b, sb), "R5", "wire data MSB first",
              int'(wire_bits), int'(exp_wire(we, b, sb)));
        check(rx_byte == exp_wire(we, b, sb), "R6", "rx_byte",
              int'(rx_byte), int'(exp_wire(we, b, sb)));
        if (we)
            check(ack == exp_ack(we, sp, sack), "R7", "write ack status",
                  int'(ack), int'(exp_ack(we, sp, sack)));
        else begin
            check(ack == exp_ack(we, sp, sack), "R8", "read ack status",
                  int'(ack), int'(exp_ack(we, sp, sack)));
            check(wire_ack == sp, "R8", "read ack line level", int'(wire_ack), int'(sp));
        end
        if (sp)
            check(!scl_pull && !sda_pull, "R3", "lines after STOP",
                  int'({scl_pull, sda_pull}), 0);
        else
            check(scl_pull == 1'b1, "R9", "SCL parked low", int'(scl_pull), 1);
        if (inj) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b0, "R10", "no transfer after stray strobe", int'(busy), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && ack == 1'b0, "R11", "busy/ack after reset",
              int'({busy, ack}), 0);
        check(rx_byte == 8'h00, "R11", "rx_byte after reset", int'(rx_byte), 0);
        check(!scl_pull && !sda_pull, "R11", "lines after reset",
              int'({scl_pull, sda_pull}), 0);

        // address write with START, slave acknowledges, bus stays owned
        run_cmd(1'b1, 1'b1, 1'b0, 8'hA0, 8'h00, 1'b1, 1'b0);
        // data write answered with NACK
        run_cmd(1'b1, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b0);
        // read without STOP: engine acknowledges and parks with SDA pulled
        run_cmd(1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0);
        // repeated START straight after the parked read acknowledge
        run_cmd(1'b1, 1'b1, 1'b0, 8'hA1, 8'h00, 1'b1, 1'b0);
        // last read with STOP: NACK on the line, bus released
        run_cmd(1'b0, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b0);
        // full frame in one command, with a stray strobe mid-transfer
        run_cmd(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1);
        // bare write from a released bus
        run_cmd(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 8'h00, 8'h81, 1'b0, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            run_cmd(r[0], r[1], r[2], 8'($urandom), 8'($urandom), 1'($urandom),
                    ($urandom % 4) == 0);
            repeat ($urandom % 6) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule